// File: doc/BRIEF.md
# Integer Execution Unit with Condition Flags

This block is the integer datapath of a simple processor pipeline stage. Each cycle it takes a first operand from a register and a second operand that is either a register value or a sign-extended 13-bit immediate. It produces a 32-bit result combinationally. The operations are addition and subtraction, six bitwise logic forms and three shifts. The addition and subtraction forms can fold in the stored carry flag.

A four-bit flag register holds negative, zero, overflow and carry. It is written on the clock edge only when the instruction asks for a flag update and the operation is an arithmetic or logic one. Shifts leave the flags alone even when an update is requested. Register file access, operand forwarding and branch evaluation sit outside the block.

Top module: `int_exec_unit`

## Requirements
- R1: When `use_imm` is 1, the second operand is `imm13` sign-extended to 32 bits (bit 12 copied into bits 31..13). Otherwise the second operand is `rs2`.
- R2: Opcodes 0/1/2/3 drive `result` with a+b, a+b+C, a−b and a−b−C respectively, modulo 2^32, where C is flag bit 0.
- R3: After an add (opcode 0 or 1) with `cc_en`=1, flag bit 0 (C) is the carry out of bit 31 and flag bit 1 (V) marks a signed overflow.
- R4: After a subtract (opcode 2 or 3) with `cc_en`=1, C is 1 exactly when the unsigned difference borrows, and V marks a signed overflow.
- R5: Opcodes 4..9 give a&b, a&~b, a|b, a|~b, a^b and a^~b.
- R6: With `cc_en`=1, every arithmetic or logic opcode loads flag bit 3 (N) with result bit 31 and flag bit 2 (Z) with result==0. Logic opcodes also clear V and C.
- R7: Opcodes 10/11/12 shift a left, logically right and arithmetically right by the low 5 bits of the second operand. The left and logical right shifts fill with zeros and the arithmetic shift fills with bit 31.
- R8: Shift opcodes never change the flags, whatever the value of `cc_en`.
- R9: The flags are zero after reset. They change only on an edge where `cc_en` is 1.
- R10: Opcodes 13..15 drive `result` to zero and never change the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation select (see R2, R5, R7, R10) |
| use_imm | input | 1 | Selects the immediate as the second operand |
| cc_en | input | 1 | Requests a flag update on this edge |
| rs1 | input | 32 | First operand |
| rs2 | input | 32 | Register second operand |
| imm13 | input | 13 | Signed immediate second operand |
| result | output | 32 | Combinational result |
| flags | output | 4 | Registered flags {N, Z, V, C} |

## Verification
A wrong flag value stays hidden until it is used. It shows on `flags` one edge after the faulty update. It also shows in the same cycle as a wrong `result` of the next carry-using add or subtract. The reference model carries its own flag state across each cycle. Any drift, such as a wrong borrow sense or a shift that touches the flags, is therefore caught at the first comparison after the edge. Directed corners cover the signed overflow limits, the carry and borrow wrap, shift amounts above 31 and a negative immediate. Random operands then cover the rest.

// File: rtl/exec_pkg.sv
package exec_pkg;
    localparam int DATA_W = 32;
    localparam int IMM_W  = 13;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUB  = 4'd2,
        OP_SUBC = 4'd3,
        OP_AND  = 4'd4,
        OP_ANDN = 4'd5,
        OP_OR   = 4'd6,
        OP_ORN  = 4'd7,
        OP_XOR  = 4'd8,
        OP_XNOR = 4'd9,
        OP_SLL  = 4'd10,
        OP_SRL  = 4'd11,
        OP_SRA  = 4'd12
    } exec_op_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;
endpackage

// File: rtl/exec_operand_sel.sv
module exec_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 13
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] reg_val,
    input  logic [IMM_W-1:0]  imm_val,
    output logic [DATA_W-1:0] operand
);
    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_ext;

    always_comb begin
        imm_ext = {{EXT_W{imm_val[IMM_W-1]}}, imm_val};
        operand = use_imm ? imm_ext : reg_val;
    end
endmodule

// File: rtl/exec_arith.sv
module exec_arith #(
    parameter int DATA_W = 32
) (
    input  logic              subtract,
    input  logic              carry_in,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] sum,
    output logic              carry_flag,
    output logic              ovf_flag
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] b_eff;
    logic              c_eff;

    always_comb begin
        // a - b - cin == a + ~b + (1 - cin)
        b_eff      = subtract ? ~b : b;
        c_eff      = subtract ? ~carry_in : carry_in;
        wide       = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, c_eff};
        sum        = wide[MSB:0];
        carry_flag = subtract ? ~wide[DATA_W] : wide[DATA_W];
        ovf_flag   = (a[MSB] == b_eff[MSB]) && (sum[MSB] != a[MSB]);
    end
endmodule

// File: rtl/exec_logic.sv
module exec_logic #(
    parameter int DATA_W = 32
) (
    input  exec_pkg::logic_kind_e kind,
    input  logic                  invert_b,
    input  logic [DATA_W-1:0]     a,
    input  logic [DATA_W-1:0]     b,
    output logic [DATA_W-1:0]     y
);
    logic [DATA_W-1:0] bb;

    always_comb begin
        bb = invert_b ? ~b : b;
        unique case (kind)
            exec_pkg::LG_AND: y = a & bb;
            exec_pkg::LG_OR:  y = a | bb;
            exec_pkg::LG_XOR: y = a ^ bb;
            default:          y = '0;
        endcase
    end
endmodule

// File: rtl/exec_shift.sv
module exec_shift #(
    parameter int DATA_W = 32
) (
    input  logic [1:0]                  mode,   // 0 left, 1 logical right, 2 arithmetic right
    input  logic [DATA_W-1:0]           a,
    input  logic [$clog2(DATA_W)-1:0]   amount,
    output logic [DATA_W-1:0]           y
);
    always_comb begin
        unique case (mode)
            2'd0:    y = a << amount;
            2'd1:    y = a >> amount;
            2'd2:    y = DATA_W'($signed(a) >>> amount);
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import exec_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [3:0]  opcode,
    input  logic        use_imm,
    input  logic        cc_en,
    input  logic [31:0] rs1,
    input  logic [31:0] rs2,
    input  logic [12:0] imm13,
    output logic [31:0] result,
    output logic [3:0]  flags
);
    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        flags_t cc;
    } state_t;

    state_t state_d, state_q;

    logic [DATA_W-1:0] op_b;
    logic [DATA_W-1:0] arith_y, logic_y, shift_y;
    logic              arith_c, arith_v;
    logic              is_sub, use_carry;
    logic              is_arith, is_logic, is_shift;
    logic_kind_e       lkind;
    logic              linv;
    logic [1:0]        smode;

    always_comb begin
        is_arith  = opcode <= OP_SUBC;
        is_logic  = (opcode >= OP_AND) && (opcode <= OP_XNOR);
        is_shift  = (opcode >= OP_SLL) && (opcode <= OP_SRA);
        is_sub    = opcode[1];
        use_carry = opcode[0];
        linv      = opcode[0];
        unique case (opcode)
            OP_OR, OP_ORN:   lkind = LG_OR;
            OP_XOR, OP_XNOR: lkind = LG_XOR;
            default:         lkind = LG_AND;
        endcase
        smode = 2'(opcode - OP_SLL);
    end

    exec_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_imm (use_imm),
        .reg_val (rs2),
        .imm_val (imm13),
        .operand (op_b)
    );

    exec_arith #(.DATA_W(DATA_W)) u_arith (
        .subtract   (is_sub),
        .carry_in   (use_carry & state_q.cc.c),
        .a          (rs1),
        .b          (op_b),
        .sum        (arith_y),
        .carry_flag (arith_c),
        .ovf_flag   (arith_v)
    );

    exec_logic #(.DATA_W(DATA_W)) u_logic (
        .kind     (lkind),
        .invert_b (linv),
        .a        (rs1),
        .b        (op_b),
        .y        (logic_y)
    );

    exec_shift #(.DATA_W(DATA_W)) u_shift (
        .mode   (smode),
        .a      (rs1),
        .amount (op_b[SH_W-1:0]),
        .y      (shift_y)
    );

    always_comb begin
        state_d = state_q;
        if (is_arith)      result = arith_y;
        else if (is_logic) result = logic_y;
        else if (is_shift) result = shift_y;
        else               result = '0;

        if (cc_en && (is_arith || is_logic)) begin
            state_d.cc.n = result[DATA_W-1];
            state_d.cc.z = (result == '0);
            state_d.cc.v = is_arith ? arith_v : 1'b0;
            state_d.cc.c = is_arith ? arith_c : 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign flags = state_q.cc;
endmodule

// File: rtl/int_exec_unit_chk.sv
module int_exec_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  opcode,
    input logic        use_imm,
    input logic        cc_en,
    input logic [31:0] rs1,
    input logic [31:0] rs2,
    input logic [12:0] imm13,
    input logic [31:0] result,
    input logic [3:0]  flags
);
    logic        shift_op, logic_op, arith_op, rsvd_op;
    logic [31:0] b_seen;

    always_comb begin
        shift_op = (opcode >= 4'd10) && (opcode <= 4'd12);
        logic_op = (opcode >= 4'd4) && (opcode <= 4'd9);
        arith_op = opcode <= 4'd3;
        rsvd_op  = opcode >= 4'd13;
        b_seen   = use_imm ? 32'($signed(imm13)) : rs2;
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> flags == 4'b0000); // R9
    AST_HOLD_NO_CC: assert property (@(posedge clk) disable iff (!rst_n) !cc_en |=> $stable(flags)); // R9
    AST_SHIFT_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n) shift_op |=> $stable(flags)); // R8
    AST_RSVD_KEEPS_CC: assert property (@(posedge clk) disable iff (!rst_n) rsvd_op |=> $stable(flags)); // R10
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) rsvd_op |-> result == 32'd0); // R10
    AST_LOGIC_VC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (cc_en && logic_op) |=> flags[1:0] == 2'b00); // R6
    AST_ZERO_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) (cc_en && (logic_op || arith_op)) |=> flags[2] == ($past(result) == 32'd0)); // R6
    AST_NEG_TRACKS: assert property (@(posedge clk) disable iff (!rst_n) (cc_en && (logic_op || arith_op)) |=> flags[3] == $past(result[31])); // R6
    AST_PLAIN_ADD: assert property (@(posedge clk) disable iff (!rst_n) opcode == 4'd0 |-> result == rs1 + b_seen); // R1
endmodule

bind int_exec_unit int_exec_unit_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .opcode  (opcode),
    .use_imm (use_imm),
    .cc_en   (cc_en),
    .rs1     (rs1),
    .rs2     (rs2),
    .imm13   (imm13),
    .result  (result),
    .flags   (flags)
);

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic        use_imm = 1'b0;
    logic        cc_en = 1'b0;
    logic [31:0] rs1 = '0;
    logic [31:0] rs2 = '0;
    logic [12:0] imm13 = '0;
    logic [31:0] result;
    logic [3:0]  flags;

    int checks = 0;
    int fails  = 0;
    logic [3:0] m_cc = 4'b0000;   // model flags {N,Z,V,C}

    always #2.5 clk = ~clk;

    int_exec_unit dut_i (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .use_imm(use_imm), .cc_en(cc_en),
        .rs1(rs1), .rs2(rs2), .imm13(imm13), .result(result), .flags(flags)
    );

    task automatic check32(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Reference model: expected result and next flags
    task automatic model(input logic [3:0] op, input logic ui, input logic ce,
                         input logic [31:0] a, input logic [31:0] r2, input logic [12:0] i13,
                         output logic [31:0] y, output logic [3:0] nxt, output string tag);
        longint     ua, ub, s, sa, sb, ss, cin;
        logic [31:0] b;
        logic        v, c;
        b   = ui ? 32'($signed(i13)) : r2;
        ua  = longint'(a);
        ub  = longint'(b);
        sa  = longint'($signed(a));
        sb  = longint'($signed(b));
        cin = (op[0] && m_cc[0]) ? 1 : 0;
        nxt = m_cc;
        v = 0; c = 0;
        y = 0;
        tag = "R10";
        if (op <= 4'd1) begin
            s = ua + ub + cin; ss = sa + sb + cin;
            y = s[31:0]; c = s[32];
            v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            tag = "R2";
        end else if (op <= 4'd3) begin
            s = ua - ub - cin; ss = sa - sb - cin;
            y = s[31:0]; c = (s < 0);
            v = (ss > 64'sd2147483647) || (ss < -64'sd2147483648);
            tag = "R2";
        end else if (op <= 4'd9) begin
            case (op)
                4'd4: y = a & b;
                4'd5: y = a & ~b;
                4'd6: y = a | b;
                4'd7: y = a | ~b;
                4'd8: y = a ^ b;
                default: y = ~(a ^ b);
            endcase
            tag = "R5";
        end else if (op <= 4'd12) begin
            int sh = int'(b % 32);
            if (op == 4'd10)      y = a << sh;
            else if (op == 4'd11) y = a >> sh;
            else                  y = $signed(a) >>> sh;
            tag = "R7";
        end
        if (ce && op <= 4'd9) nxt = {y[31], (y == 0), v, c};
    endtask

    task automatic step(input logic [3:0] op, input logic ui, input logic ce,
                        input logic [31:0] a, input logic [31:0] r2, input logic [12:0] i13);
        logic [31:0] exp_y;
        logic [3:0]  exp_cc;
        string       tag;
        @(negedge clk);
        opcode = op; use_imm = ui; cc_en = ce; rs1 = a; rs2 = r2; imm13 = i13;
        #1;
        model(op, ui, ce, a, r2, i13, exp_y, exp_cc, tag);
        check32(tag, result, exp_y);
        @(posedge clk);
        #1;
        m_cc = exp_cc;
        check32("R3 R4 R6 R8 R9 R10 flags", {28'd0, flags}, {28'd0, m_cc});
    endtask

    initial begin
        #100000;
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check32("R9 reset", {28'd0, flags}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: negative immediate sign extension
        step(4'd0, 1'b1, 1'b1, 32'd10, 32'hDEAD_BEEF, 13'h1FFF);
        step(4'd6, 1'b1, 1'b0, 32'd0, 32'd0, 13'h1000);
        // R3: signed overflow and carry wrap to zero
        step(4'd0, 1'b0, 1'b1, 32'h7FFF_FFFF, 32'd1, 13'd0);
        step(4'd0, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd1, 13'd0);
        // R2: carry-using add with C=1
        step(4'd1, 1'b0, 1'b1, 32'd5, 32'd6, 13'd0);
        // R4: borrow and signed overflow on subtract
        step(4'd2, 1'b0, 1'b1, 32'd0, 32'd1, 13'd0);
        step(4'd3, 1'b0, 1'b1, 32'd9, 32'd3, 13'd0);
        step(4'd2, 1'b0, 1'b1, 32'h8000_0000, 32'd1, 13'd0);
        // R8: shifts with cc_en must keep flags
        step(4'd12, 1'b0, 1'b1, 32'h8000_0010, 32'd4, 13'd0);
        step(4'd10, 1'b1, 1'b1, 32'h0000_0003, 32'd0, 13'd33);
        step(4'd11, 1'b0, 1'b1, 32'hF000_0000, 32'd35, 13'd0);
        // R9: no update without cc_en
        step(4'd2, 1'b0, 1'b0, 32'd0, 32'd0, 13'd0);
        // R6: logic clears V and C
        step(4'd9, 1'b0, 1'b1, 32'h1234_5678, 32'h1234_5678, 13'd0);
        step(4'd7, 1'b0, 1'b1, 32'd0, 32'hFFFF_FFFF, 13'd0);
        // R10: reserved codes
        step(4'd13, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'd1, 13'd0);
        step(4'd15, 1'b0, 1'b1, 32'd1, 32'd1, 13'd0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra;
            ra = $urandom;
            if (i % 7 == 0) ra = 32'h8000_0000;
            step(4'($urandom % 16), 1'($urandom), 1'($urandom), ra, $urandom, 13'($urandom));
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule